// File: doc/BRIEF.md
# Bulk Processor State Load Sequencer

This block carries out a single instruction that replaces a processor's whole execution state from a fixed image in physical memory. A one-cycle start pulse begins the sequence. The block first checks the operating mode and the current privilege level. If the load is allowed, it reads the image one 16-bit word at a time over a simple read bus. It then writes the words out through two write ports. The first port carries 16-bit registers: the MSW, the selectors, flags, IP and the general registers. The second port carries the 48-bit descriptor-cache, GDTR and IDTR images. No descriptor table is read, and no type or access-rights check is made on the values that are loaded.

Every word that is read goes into an internal image buffer first. The register write ports fire only after the last of the 51 reads has completed. A privilege fault therefore leaves every register untouched. While the processor is in protected mode, the loaded MSW always leaves with bit 0 set, so the instruction cannot return the processor to real mode.

The read bus is a valid/ready channel. `mem_req` is the valid, with `mem_addr` as its payload. `mem_rdy` is the memory's ready and also qualifies `mem_rdata` in the same cycle. The memory applies back-pressure by holding `mem_rdy` low. While it does, the block keeps `mem_req` high and `mem_addr` unchanged. The block never withdraws a request. The write ports have no back-pressure: the receiving register file must take a write in the cycle it is presented.

Top module: `state_load_seq`

## Requirements
- R1: After reset, busy, mem_req, word_we, cache_we, done and fault are all low.
- R2: A load reads exactly 51 words, at addresses BASE_ADDR+2n for n = 0 to 50 in ascending order (BASE_ADDR defaults to 0x000800). A word is taken only in a cycle where mem_req and mem_rdy are both high. While mem_rdy is low, mem_req stays high and mem_addr holds its value.
- R3: A start seen in protected mode (prot_mode=1) with cur_cpl not 0 raises fault for one cycle in the next cycle, with fault_code 0. No read is issued and no write port fires.
- R4: In real mode (prot_mode=0), a load runs to completion whatever the value of cur_cpl.
- R5: No write fires before the 51st read has completed. The block then issues 25 writes in 25 consecutive cycles: word indices 0 to 16 first, then cache indices 0 to 7.
- R6: Word index 0 is the MSW, taken from byte offset 0x06. Word indices 1 to 16 come from byte offset 0x16+2(i-1), low byte first, in this order: TR, flags, IP, LDT, DS, SS, CS, ES, DI, SI, BP, SP, BX, DX, CX, AX.
- R7: Cache index k comes from byte offset 0x36+6k, in this order: ES, CS, SS, DS, GDTR, LDT, IDTR, TSS. The base is bytes 0 to 2 (low byte first), the access byte is byte 3, and the limit is bytes 4 to 5 (low byte first).
- R8: For cache index 4 (GDTR) and cache index 6 (IDTR), cache_ar is 0, whatever byte 3 of the image holds.
- R9: If prot_mode was 1 at start, bit 0 of the written MSW is 1. In real mode, the MSW is written exactly as read.
- R10: done pulses for one cycle, in the cycle after the last cache write. From then on, new_cpl equals bits 6:5 of the CS access byte. dpl_mismatch is 1 exactly when those bits differ from bits 6:5 of the SS access byte.
- R11: A start pulse while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the load |
| prot_mode | input | 1 | Processor is in protected mode |
| cur_cpl | input | 2 | Current privilege level |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle privilege fault pulse |
| fault_code | output | 16 | Error code that goes with the fault (always 0) |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | 24 | Physical byte address of the word being read |
| mem_rdy | input | 1 | Memory ready; mem_rdata is valid in this cycle |
| mem_rdata | input | 16 | Read data |
| word_we | output | 1 | Register word write strobe |
| word_idx | output | 5 | Register index (0 MSW, 1..16 TR..AX) |
| word_data | output | 16 | Register word value |
| cache_we | output | 1 | Descriptor image write strobe |
| cache_idx | output | 3 | Image index (0 ES .. 7 TSS) |
| cache_base | output | 24 | Image base address |
| cache_ar | output | 8 | Image access byte |
| cache_lim | output | 16 | Image limit |
| new_cpl | output | 2 | CPL taken from the loaded CS image |
| dpl_mismatch | output | 1 | CS and SS image DPL fields differ |

## Verification
The hardest case to reach is a start pulse that arrives in the middle of a load that is being stalled. If that pulse were honoured, the read sequence would restart. The only visible sign would be the address order, and only while the bus is withholding ready. The bench throttles ready with a pseudo-random pattern and fires a second start pulse deep inside the fetch. A reference counter checks every requested address on every clock. Separate runs force MSW bit 0 to zero, put a nonzero byte 3 into the GDTR and IDTR images, and set the CS and SS DPL fields apart from each other.

// File: rtl/sls_pkg.sv
package sls_pkg;
  localparam int SLS_AW        = 24;
  localparam int SLS_DW        = 16;
  localparam int SLS_NWORDS    = 51;
  localparam int SLS_NREGS     = 17;
  localparam int SLS_NCACHE    = 8;
  localparam int SLS_MSW_WORD  = 3;   // byte 0x06
  localparam int SLS_REG_WORD0 = 11;  // byte 0x16
  localparam int SLS_IMG_WORD0 = 27;  // byte 0x36
  localparam int SLS_IMG_WORDS = 3;
  localparam int SLS_CS_SLOT   = 1;
  localparam int SLS_SS_SLOT   = 2;
  localparam logic [SLS_NCACHE-1:0] SLS_SYS_MASK = 8'b0101_0000; // GDTR, IDTR

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_COMMIT} sls_state_t;
endpackage

// File: rtl/sls_fetch.sv
module sls_fetch #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int NW = 51,
  parameter logic [AW-1:0] BASE = 24'h000800,
  localparam int IW = $clog2(NW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rdy,
  input  logic [DW-1:0] mem_rdata,
  output logic          cap_en,
  output logic [IW-1:0] cap_idx,
  output logic [DW-1:0] cap_data,
  output logic          last
);
  logic          active;
  logic [IW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (go) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active && mem_rdy) begin
      if (cnt == IW'(NW - 1)) active <= 1'b0;
      else                    cnt    <= cnt + 1'b1;
    end
  end

  assign mem_req  = active;
  assign mem_addr = BASE + AW'({cnt, 1'b0});
  assign cap_en   = active && mem_rdy;
  assign cap_idx  = cnt;
  assign cap_data = mem_rdata;
  assign last     = cap_en && (cnt == IW'(NW - 1));

  // R2
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr)));
  // R2
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[0] == 1'b0 && mem_addr >= BASE && mem_addr < BASE + AW'(2*NW)));
endmodule

// File: rtl/sls_commit.sv
module sls_commit
  import sls_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 51,
  parameter int NR = 17,
  parameter int NC = 8,
  localparam int IW = $clog2(NW),
  localparam int RW = $clog2(NR),
  localparam int KW = $clog2(NC),
  localparam int CW = $clog2(NR + NC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [IW-1:0]    cap_idx,
  input  logic [DW-1:0]    cap_data,
  input  logic             go,
  input  logic             prot_lat,
  output logic             word_we,
  output logic [RW-1:0]    word_idx,
  output logic [DW-1:0]    word_data,
  output logic             cache_we,
  output logic [KW-1:0]    cache_idx,
  output logic [23:0]      cache_base,
  output logic [7:0]       cache_ar,
  output logic [15:0]      cache_lim,
  output logic             fin,
  output logic [1:0]       cs_dpl,
  output logic [1:0]       ss_dpl
);
  logic [DW-1:0] img [NW];
  logic          active;
  logic [CW-1:0] cidx;
  logic [IW-1:0] src_w, w0, w1, w2;
  logic [KW-1:0] slot;
  logic [NC-1:0] sys_mask;

  always_ff @(posedge clk) begin
    if (cap_en) img[cap_idx] <= cap_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cidx   <= '0;
    end else if (go) begin
      active <= 1'b1;
      cidx   <= '0;
    end else if (active) begin
      if (cidx == CW'(NR + NC - 1)) active <= 1'b0;
      else                          cidx   <= cidx + 1'b1;
    end
  end

  for (genvar g = 0; g < NC; g++) begin : g_sys
    assign sys_mask[g] = SLS_SYS_MASK[g];
  end

  always_comb begin
    src_w = (cidx == '0) ? IW'(SLS_MSW_WORD) : IW'(SLS_REG_WORD0 - 1 + int'(cidx));
    slot  = KW'(int'(cidx) - NR);
    w0    = IW'(SLS_IMG_WORD0 + SLS_IMG_WORDS * int'(slot));
    w1    = IW'(SLS_IMG_WORD0 + SLS_IMG_WORDS * int'(slot) + 1);
    w2    = IW'(SLS_IMG_WORD0 + SLS_IMG_WORDS * int'(slot) + 2);
  end

  assign word_we    = active && (cidx < CW'(NR));
  assign word_idx   = RW'(cidx);
  assign word_data  = img[src_w] | {{(DW-1){1'b0}}, (cidx == '0) && prot_lat};
  assign cache_we   = active && (cidx >= CW'(NR));
  assign cache_idx  = slot;
  assign cache_base = {img[w1][7:0], img[w0]};
  assign cache_ar   = sys_mask[slot] ? 8'h00 : img[w1][15:8];
  assign cache_lim  = img[w2];
  assign fin        = active && (cidx == CW'(NR + NC - 1));
  assign cs_dpl     = img[SLS_IMG_WORD0 + SLS_IMG_WORDS*SLS_CS_SLOT + 1][14:13];
  assign ss_dpl     = img[SLS_IMG_WORD0 + SLS_IMG_WORDS*SLS_SS_SLOT + 1][14:13];

  // R8
  sys_ar_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_we && sys_mask[cache_idx]) |-> (cache_ar == 8'h00));
  // R9
  msw_pe_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we && word_idx == '0 && prot_lat) |-> word_data[0]);
  // R5
  word_then_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we && word_idx == RW'(NR - 1)) |=> (cache_we && cache_idx == '0));
endmodule

// File: rtl/state_load_seq.sv
module state_load_seq
  import sls_pkg::*;
#(
  parameter logic [SLS_AW-1:0] BASE_ADDR = 24'h000800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              prot_mode,
  input  logic [1:0]        cur_cpl,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [15:0]       fault_code,
  output logic              mem_req,
  output logic [SLS_AW-1:0] mem_addr,
  input  logic              mem_rdy,
  input  logic [SLS_DW-1:0] mem_rdata,
  output logic              word_we,
  output logic [4:0]        word_idx,
  output logic [SLS_DW-1:0] word_data,
  output logic              cache_we,
  output logic [2:0]        cache_idx,
  output logic [23:0]       cache_base,
  output logic [7:0]        cache_ar,
  output logic [15:0]       cache_lim,
  output logic [1:0]        new_cpl,
  output logic              dpl_mismatch
);
  localparam int IW = $clog2(SLS_NWORDS);

  sls_state_t    state;
  logic          prot_lat, refused, go_fetch, fetch_last, commit_fin;
  logic          cap_en;
  logic [IW-1:0] cap_idx;
  logic [SLS_DW-1:0] cap_data;
  logic [1:0]    cs_dpl, ss_dpl;

  assign refused  = prot_mode && (cur_cpl != 2'd0);
  assign go_fetch = (state == ST_IDLE) && start && !refused;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      prot_lat     <= 1'b0;
      fault        <= 1'b0;
      done         <= 1'b0;
      new_cpl      <= 2'd0;
      dpl_mismatch <= 1'b0;
    end else begin
      fault <= 1'b0;
      done  <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          if (refused) fault <= 1'b1;
          else begin
            state    <= ST_FETCH;
            prot_lat <= prot_mode;
          end
        end
        ST_FETCH: if (fetch_last) state <= ST_COMMIT;
        ST_COMMIT: if (commit_fin) begin
          state        <= ST_IDLE;
          done         <= 1'b1;
          new_cpl      <= cs_dpl;
          dpl_mismatch <= (cs_dpl != ss_dpl);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign fault_code = 16'h0000;

  sls_fetch #(.AW(SLS_AW), .DW(SLS_DW), .NW(SLS_NWORDS), .BASE(BASE_ADDR)) fetch_u (
    .clk(clk), .rst_n(rst_n), .go(go_fetch),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
    .cap_en(cap_en), .cap_idx(cap_idx), .cap_data(cap_data), .last(fetch_last)
  );

  sls_commit #(.DW(SLS_DW), .NW(SLS_NWORDS), .NR(SLS_NREGS), .NC(SLS_NCACHE)) commit_u (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cap_idx), .cap_data(cap_data),
    .go(fetch_last), .prot_lat(prot_lat),
    .word_we(word_we), .word_idx(word_idx), .word_data(word_data),
    .cache_we(cache_we), .cache_idx(cache_idx), .cache_base(cache_base),
    .cache_ar(cache_ar), .cache_lim(cache_lim), .fin(commit_fin),
    .cs_dpl(cs_dpl), .ss_dpl(ss_dpl)
  );

  // R3
  priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && refused) |=> (fault && !mem_req && !busy));
  // R5
  no_write_during_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we || cache_we) |-> !mem_req);
  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(cache_we) && $past(cache_idx) == 3'd7));
  // R11
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH && !fetch_last) |=> (state == ST_FETCH || state == ST_COMMIT));
endmodule

// File: tb/state_load_seq_tb.sv
module state_load_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 'h800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        prot_mode = 1'b0;
  logic [1:0]  cur_cpl = 2'd0;
  logic        busy, done, fault, mem_req, mem_rdy, word_we, cache_we, dpl_mismatch;
  logic [15:0] fault_code, mem_rdata, word_data, cache_lim;
  logic [23:0] mem_addr, cache_base;
  logic [4:0]  word_idx;
  logic [2:0]  cache_idx;
  logic [7:0]  cache_ar;
  logic [1:0]  new_cpl;

  logic [7:0]  mem_b [102];
  logic [15:0] lf = 16'hACE1;
  int total = 0, bad = 0, cycles = 0;
  int rd_cnt = 0, wr_cnt = 0;
  bit done_seen = 0, fault_seen = 0, stall = 0, mon_on = 0, exp_prot = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  state_load_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .prot_mode(prot_mode), .cur_cpl(cur_cpl),
    .busy(busy), .done(done), .fault(fault), .fault_code(fault_code),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdy(mem_rdy), .mem_rdata(mem_rdata),
    .word_we(word_we), .word_idx(word_idx), .word_data(word_data),
    .cache_we(cache_we), .cache_idx(cache_idx), .cache_base(cache_base),
    .cache_ar(cache_ar), .cache_lim(cache_lim), .new_cpl(new_cpl), .dpl_mismatch(dpl_mismatch)
  );

  // memory model: byte image, little-endian words
  always_comb begin
    int o;
    o = int'(mem_addr) - BASE;
    if (o >= 0 && o < 101) mem_rdata = {mem_b[o+1], mem_b[o]};
    else mem_rdata = 16'hDEAD;
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] nxt();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[7:0];
  endfunction

  function automatic logic [15:0] exp_word(int i);
    int o;
    o = (i == 0) ? 6 : 'h16 + 2*(i-1);
    return {mem_b[o+1], mem_b[o]} | ((i == 0 && exp_prot) ? 16'h1 : 16'h0);
  endfunction

  // reference model compared every clock
  always @(negedge clk) begin
    if (mon_on) begin
      if (mem_req) begin
        chk(mem_addr == 24'(BASE + 2*rd_cnt), "R2", "read address", mem_addr, BASE + 2*rd_cnt);
        mem_rdy = stall ? nxt()[0] : 1'b1;
        if (mem_rdy) rd_cnt++;
      end else mem_rdy = 1'b0;
      if (word_we) begin
        chk(rd_cnt == 51, "R5", "reads before write", rd_cnt, 51);
        chk(word_idx == 5'(wr_cnt), "R5", "word order", word_idx, wr_cnt);
        chk(word_data == exp_word(wr_cnt), wr_cnt == 0 ? "R9" : "R6", "word data", word_data, exp_word(wr_cnt));
        wr_cnt++;
      end
      if (cache_we) begin
        int k, o;
        logic [7:0] ear;
        k = wr_cnt - 17;
        o = 'h36 + 6*k;
        ear = (k == 4 || k == 6) ? 8'h00 : mem_b[o+3];
        chk(wr_cnt >= 17 && cache_idx == 3'(k), "R5", "cache order", cache_idx, k);
        chk(cache_base == {mem_b[o+2], mem_b[o+1], mem_b[o]}, "R7", "cache base", cache_base, {mem_b[o+2], mem_b[o+1], mem_b[o]});
        chk(cache_lim == {mem_b[o+5], mem_b[o+4]}, "R7", "cache limit", cache_lim, {mem_b[o+5], mem_b[o+4]});
        chk(cache_ar == ear, (k == 4 || k == 6) ? "R8" : "R7", "cache access byte", cache_ar, ear);
        wr_cnt++;
      end
      if (done) begin
        logic [1:0] c, s;
        c = mem_b['h3C+3][6:5];
        s = mem_b['h42+3][6:5];
        chk(wr_cnt == 25 && !busy, "R10", "done timing", wr_cnt, 25);
        chk(new_cpl == c, "R10", "new cpl", new_cpl, c);
        chk(dpl_mismatch == (c != s), "R10", "dpl mismatch", dpl_mismatch, c != s);
        done_seen = 1;
      end
      if (fault) begin
        chk(fault_code == 16'h0, "R3", "fault code", fault_code, 0);
        fault_seen = 1;
      end
    end
  end

  task automatic fill();
    for (int i = 0; i < 102; i++) mem_b[i] = nxt();
  endtask

  task automatic run(input bit pm, input logic [1:0] cpl, input bit stl, input bit refuse, input bit restart);
    int w;
    rd_cnt = 0; wr_cnt = 0; done_seen = 0; fault_seen = 0;
    stall = stl; exp_prot = pm;
    @(negedge clk);
    prot_mode = pm; cur_cpl = cpl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      repeat (20) @(negedge clk);
      chk(busy == 1'b1, "R11", "busy mid load", busy, 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!done_seen && !fault_seen && w < 2000) begin
      @(negedge clk);
      w++;
    end
    repeat (4) @(negedge clk);
    if (refuse) begin
      chk(fault_seen && !done_seen, "R3", "fault raised", fault_seen, 1);
      chk(rd_cnt == 0 && wr_cnt == 0, "R3", "no reads or writes", rd_cnt + wr_cnt, 0);
    end else begin
      chk(done_seen && !fault_seen, pm ? "R2" : "R4", "load completed", done_seen, 1);
      chk(rd_cnt == 51, "R2", "read count", rd_cnt, 51);
      chk(wr_cnt == 25, "R5", "write count", wr_cnt, 25);
    end
    chk(!busy, "R11", "idle after run", busy, 0);
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mem_rdy = 1'b0;
    fill();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_req && !word_we && !cache_we && !done && !fault, "R1", "reset outputs",
        {busy, mem_req, word_we, cache_we, done, fault}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req, "R1", "idle after reset", {busy, mem_req}, 0);
    mon_on = 1;

    // R4 real mode, cpl nonzero ignored, MSW bit0 clear stays clear
    mem_b[6] = 8'hF0;
    run(1'b0, 2'd3, 1'b0, 1'b0, 1'b0);
    // R9 protected mode, MSW bit0 clear is forced, stalled bus
    fill(); mem_b[6] = 8'h00;
    run(1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
    // R3 privilege fault for each nonzero level
    for (int c = 1; c < 4; c++) run(1'b1, 2'(c), 1'b0, 1'b1, 1'b0);
    // R10 mismatch; R8 nonzero byte 3 in GDTR/IDTR
    fill();
    mem_b['h3C+3] = 8'h92; mem_b['h42+3] = 8'hF2;
    mem_b['h4E+3] = 8'h5A; mem_b['h5A+3] = 8'hA5;
    run(1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
    // R10 matching DPL
    mem_b['h3C+3] = 8'hBA; mem_b['h42+3] = 8'hB2;
    run(1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
    // R11 start during a stalled fetch is ignored
    fill();
    run(1'b1, 2'd0, 1'b1, 1'b0, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule